// File: doc/BRIEF.md
# Fault-Bypass Output Port with Backup Ring Path

This block is the output stage of one port of a five-port mesh router (four neighbour directions plus the local core). Flits are 64 bits wide, carry a virtual-channel tag and move by wormhole switching as head, body and tail flits. In normal operation the port forwards whatever the crossbar presents for it. When either of two static fault flags is raised, one for the crossbar path and one for the local network interface, the crossbar is taken out of use. The port then serves two other sources: one fixed neighbour input and the local core injection path. Across routers, the fixed input-to-output pairings form a one-way ring that keeps every healthy core reachable.

A three-way selector chooses among the crossbar, the ring input and the core. A small state machine locks the output to one source from an accepted head flit until that packet's tail flit passes. When the ring input and the core contend at a packet boundary, a round-robin bit decides between them. All four edges use valid/ready handshaking, and one flit moves when the output's valid and ready are both high. Flits taken from the ring have their VC tag raised to at least a configured floor and never lowered.

The state machine has four states. `ST_IDLE` means no packet is locked. `ST_XBAR`, `ST_RING` and `ST_CORE` each mean a packet from that source holds the port. The transitions are as follows. *Lock*: `ST_IDLE` moves to the source's state when a head flit (kind 01) is accepted. *Single*: `ST_IDLE` stays in `ST_IDLE` when a one-flit packet (kind 11) is accepted. *Release*: a locked state returns to `ST_IDLE` when a tail (10) or one-flit packet is accepted. *Hold*: every other cycle, including stalls, keeps the current state.

Top module: `fbp_out_port`

## Requirements
- R1: After reset no packet is locked, the round-robin bit prefers the ring source, and with both fault flags low a valid crossbar head flit is forwarded at once.
- R2: With both fault flags low and no packet locked, the output shows the crossbar's valid, kind, VC and data unchanged, `xbar_ready` equals `out_ready`, and `ring_ready` and `core_ready` stay low.
- R3: With either fault flag high and no packet locked, the crossbar is ignored (`xbar_ready` low) and only ring or core flits can be forwarded.
- R4: Flit kind is encoded 00 body, 01 head, 10 tail, 11 single-flit packet. With no packet locked, only a 01 or 11 flit from an eligible source can start a transfer. A 00 or 10 flit is not forwarded and its source sees ready low.
- R5: Once a 01 head from a source is accepted, only that source is forwarded, and the other sources see ready low, until a 10 or 11 flit from it is accepted. The output valid follows the locked source's valid.
- R6: When the ring and core both offer a start flit with no packet locked in bypass mode, the one preferred by the round-robin bit wins. Every accepted start flit from ring sets the preference to core, and every one from core sets it to ring.
- R7: While `out_ready` is low, every source ready is low, the lock does not change, and the output shows the selected source's current flit.
- R8: A change of the fault flags while a packet is locked has no effect until that packet's final flit is accepted.
- R9: A flit forwarded from the ring leaves with VC tag max(`ring_vc`, RING_MIN_VC). Crossbar and core flits keep their VC tag.
- R10: At most one source ready is high in any cycle, and a source ready is high only when `out_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fault_xbar | input | 1 | Crossbar path for this port is faulty |
| fault_ni | input | 1 | Local network interface is faulty |
| xbar_valid | input | 1 | Crossbar flit valid |
| xbar_kind | input | 2 | Crossbar flit kind |
| xbar_vc | input | VC_W | Crossbar flit VC tag |
| xbar_flit | input | FLIT_W | Crossbar flit data |
| xbar_ready | output | 1 | Crossbar flit taken |
| ring_valid | input | 1 | Backup ring input flit valid |
| ring_kind | input | 2 | Ring flit kind |
| ring_vc | input | VC_W | Ring flit VC tag |
| ring_flit | input | FLIT_W | Ring flit data |
| ring_ready | output | 1 | Ring flit taken |
| core_valid | input | 1 | Core injection flit valid |
| core_kind | input | 2 | Core flit kind |
| core_vc | input | VC_W | Core flit VC tag |
| core_flit | input | FLIT_W | Core flit data |
| core_ready | output | 1 | Core flit taken |
| out_valid | output | 1 | Output flit valid |
| out_kind | output | 2 | Output flit kind |
| out_vc | output | VC_W | Output flit VC tag |
| out_flit | output | FLIT_W | Output flit data |
| out_ready | input | 1 | Downstream accepts the flit |

## Verification
Directed patterns come first. A crossbar head with flags low is compared against ring and core heads under a fault flag to separate normal from bypass selection. Body and tail flits at an idle port separate packet-start gating from plain forwarding. Back-to-back single-flit ring and core packets separate true alternation from fixed priority. A stalled locked packet and a flag flip in mid-packet show whether the lock holds. A long constrained-random run follows, with random kinds, valids, back-pressure and rare flag changes, and checks the interleaving of lock, release and arbitration against a bench model.

// File: rtl/fbp_pkg.sv
package fbp_pkg;

    // flit kind on the wire
    typedef enum logic [1:0] {
        K_BODY   = 2'b00,
        K_HEAD   = 2'b01,
        K_TAIL   = 2'b10,
        K_SINGLE = 2'b11
    } kind_e;

    // source picked by the output selector
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_XBAR = 2'd1,
        SRC_RING = 2'd2,
        SRC_CORE = 2'd3
    } src_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XBAR = 2'd1,
        ST_RING = 2'd2,
        ST_CORE = 2'd3
    } state_e;

    localparam int NUM_SRC = 3;

    function automatic logic is_start(input logic [1:0] k);
        return (k == K_HEAD) || (k == K_SINGLE);
    endfunction

    function automatic logic is_end(input logic [1:0] k);
        return (k == K_TAIL) || (k == K_SINGLE);
    endfunction

endpackage

// File: rtl/fbp_lock_fsm.sv
module fbp_lock_fsm
    import fbp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fault_xbar,
    input  logic       fault_ni,
    input  logic       x_valid,
    input  logic [1:0] x_kind,
    input  logic       r_valid,
    input  logic [1:0] r_kind,
    input  logic       c_valid,
    input  logic [1:0] c_kind,
    input  logic       out_ready,
    output src_e       sel
);

    state_e     state_q, state_d;
    logic       rr_q, rr_d;      // 1: core preferred
    logic       bypass;
    logic       r_go, c_go;
    logic       sel_valid;
    logic [1:0] sel_kind;
    logic       fire;

    assign bypass = fault_xbar | fault_ni;
    assign r_go   = r_valid && is_start(r_kind);
    assign c_go   = c_valid && is_start(c_kind);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rr_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            rr_q    <= rr_d;
        end
    end

    // output: selection
    always_comb begin
        sel = SRC_NONE;
        unique case (state_q)
            ST_IDLE: begin
                if (!bypass) begin
                    if (x_valid && is_start(x_kind)) sel = SRC_XBAR;
                end else if (r_go && c_go) begin
                    sel = rr_q ? SRC_CORE : SRC_RING;
                end else if (r_go) begin
                    sel = SRC_RING;
                end else if (c_go) begin
                    sel = SRC_CORE;
                end
            end
            ST_XBAR: sel = SRC_XBAR;
            ST_RING: sel = SRC_RING;
            ST_CORE: sel = SRC_CORE;
            default: sel = SRC_NONE;
        endcase
    end

    always_comb begin
        unique case (sel)
            SRC_XBAR: begin sel_valid = x_valid; sel_kind = x_kind; end
            SRC_RING: begin sel_valid = r_valid; sel_kind = r_kind; end
            SRC_CORE: begin sel_valid = c_valid; sel_kind = c_kind; end
            default:  begin sel_valid = 1'b0;    sel_kind = K_BODY; end
        endcase
    end

    assign fire = sel_valid && out_ready;

    // next state: lock, single, release, hold
    always_comb begin
        state_d = state_q;
        rr_d    = rr_q;
        if (fire) begin
            if (state_q == ST_IDLE) begin
                if (sel == SRC_RING) rr_d = 1'b1;
                if (sel == SRC_CORE) rr_d = 1'b0;
                if (sel_kind == K_HEAD) begin
                    unique case (sel)
                        SRC_XBAR: state_d = ST_XBAR;
                        SRC_RING: state_d = ST_RING;
                        SRC_CORE: state_d = ST_CORE;
                        default:  state_d = ST_IDLE;
                    endcase
                end
            end else if (is_end(sel_kind)) begin
                state_d = ST_IDLE;
            end
        end
    end

endmodule

// File: rtl/fbp_vc_lift.sv
module fbp_vc_lift #(
    parameter int VC_W   = 1,
    parameter int MIN_VC = 1
) (
    input  logic [VC_W-1:0] vc_in,
    output logic [VC_W-1:0] vc_out
);
    localparam logic [VC_W-1:0] FLOOR = VC_W'(MIN_VC);

    assign vc_out = (vc_in < FLOOR) ? FLOOR : vc_in;
endmodule

// File: rtl/fbp_sel_mux.sv
module fbp_sel_mux
    import fbp_pkg::*;
#(
    parameter int FLIT_W = 64,
    parameter int VC_W   = 1
) (
    input  src_e                    sel,
    input  logic [NUM_SRC-1:0]      s_valid,
    input  logic [NUM_SRC-1:0][1:0] s_kind,
    input  logic [NUM_SRC-1:0][VC_W-1:0]   s_vc,
    input  logic [NUM_SRC-1:0][FLIT_W-1:0] s_flit,
    input  logic                    out_ready,
    output logic [NUM_SRC-1:0]      s_ready,
    output logic                    out_valid,
    output logic [1:0]              out_kind,
    output logic [VC_W-1:0]         out_vc,
    output logic [FLIT_W-1:0]       out_flit
);

    // source index i is selected by code i+1
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_rdy
        assign s_ready[i] = out_ready && (sel == src_e'(i + 1));
    end

    always_comb begin
        out_valid = 1'b0;
        out_kind  = '0;
        out_vc    = '0;
        out_flit  = '0;
        if (sel != SRC_NONE) begin
            out_valid = s_valid[sel - 2'd1];
            out_kind  = s_kind[sel - 2'd1];
            out_vc    = s_vc[sel - 2'd1];
            out_flit  = s_flit[sel - 2'd1];
        end
    end

endmodule

// File: rtl/fbp_out_port.sv
module fbp_out_port
    import fbp_pkg::*;
#(
    parameter int FLIT_W      = 64,
    parameter int VC_W        = 1,
    parameter int RING_MIN_VC = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fault_xbar,
    input  logic              fault_ni,
    input  logic              xbar_valid,
    input  logic [1:0]        xbar_kind,
    input  logic [VC_W-1:0]   xbar_vc,
    input  logic [FLIT_W-1:0] xbar_flit,
    output logic              xbar_ready,
    input  logic              ring_valid,
    input  logic [1:0]        ring_kind,
    input  logic [VC_W-1:0]   ring_vc,
    input  logic [FLIT_W-1:0] ring_flit,
    output logic              ring_ready,
    input  logic              core_valid,
    input  logic [1:0]        core_kind,
    input  logic [VC_W-1:0]   core_vc,
    input  logic [FLIT_W-1:0] core_flit,
    output logic              core_ready,
    output logic              out_valid,
    output logic [1:0]        out_kind,
    output logic [VC_W-1:0]   out_vc,
    output logic [FLIT_W-1:0] out_flit,
    input  logic              out_ready
);

    src_e                           sel;
    logic [VC_W-1:0]                ring_vc_up;
    logic [NUM_SRC-1:0]             rdy;

    fbp_lock_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .fault_xbar (fault_xbar),
        .fault_ni   (fault_ni),
        .x_valid    (xbar_valid),
        .x_kind     (xbar_kind),
        .r_valid    (ring_valid),
        .r_kind     (ring_kind),
        .c_valid    (core_valid),
        .c_kind     (core_kind),
        .out_ready  (out_ready),
        .sel        (sel)
    );

    fbp_vc_lift #(.VC_W(VC_W), .MIN_VC(RING_MIN_VC)) u_lift (
        .vc_in  (ring_vc),
        .vc_out (ring_vc_up)
    );

    fbp_sel_mux #(.FLIT_W(FLIT_W), .VC_W(VC_W)) u_mux (
        .sel       (sel),
        .s_valid   ({core_valid, ring_valid, xbar_valid}),
        .s_kind    ({core_kind, ring_kind, xbar_kind}),
        .s_vc      ({core_vc, ring_vc_up, xbar_vc}),
        .s_flit    ({core_flit, ring_flit, xbar_flit}),
        .out_ready (out_ready),
        .s_ready   (rdy),
        .out_valid (out_valid),
        .out_kind  (out_kind),
        .out_vc    (out_vc),
        .out_flit  (out_flit)
    );

    assign xbar_ready = rdy[0];
    assign ring_ready = rdy[1];
    assign core_ready = rdy[2];

endmodule

// File: rtl/fbp_out_port_chk.sv
module fbp_out_port_chk #(
    parameter int FLIT_W = 64,
    parameter int VC_W   = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fault_xbar,
    input logic              fault_ni,
    input logic              xbar_valid,
    input logic [1:0]        xbar_kind,
    input logic [VC_W-1:0]   xbar_vc,
    input logic [FLIT_W-1:0] xbar_flit,
    input logic              xbar_ready,
    input logic              ring_valid,
    input logic [1:0]        ring_kind,
    input logic [VC_W-1:0]   ring_vc,
    input logic [FLIT_W-1:0] ring_flit,
    input logic              ring_ready,
    input logic              core_valid,
    input logic [1:0]        core_kind,
    input logic [VC_W-1:0]   core_vc,
    input logic [FLIT_W-1:0] core_flit,
    input logic              core_ready,
    input logic              out_valid,
    input logic [1:0]        out_kind,
    input logic [VC_W-1:0]   out_vc,
    input logic [FLIT_W-1:0] out_flit,
    input logic              out_ready
);

    // lock owner seen at the ports: 0 none, 1 xbar, 2 ring, 3 core
    logic [1:0] lk;
    logic       fire;
    assign fire = out_valid && out_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lk <= 2'd0;
        end else if (fire) begin
            if (out_kind == 2'b01)
                lk <= xbar_ready ? 2'd1 : ring_ready ? 2'd2 : core_ready ? 2'd3 : lk;
            else if (out_kind == 2'b10 || out_kind == 2'b11)
                lk <= 2'd0;
        end
    end

    // R10
    one_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({xbar_ready, ring_ready, core_ready}));

    // R10
    ready_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xbar_ready || ring_ready || core_ready) |-> out_ready);

    // R2
    normal_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk == 2'd0 && !fault_xbar && !fault_ni) |-> (!ring_ready && !core_ready));

    // R3
    bypass_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk == 2'd0 && (fault_xbar || fault_ni)) |-> !xbar_ready);

    // R4
    no_mid_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk == 2'd0 && xbar_valid && !xbar_kind[0]) |-> !xbar_ready);

    // R5
    lock_xbar_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk == 2'd1) |-> (!ring_ready && !core_ready));

    // R5
    lock_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk == 2'd2) |-> (!xbar_ready && !core_ready));

    // R5
    lock_core_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk == 2'd3) |-> (!xbar_ready && !ring_ready));

    // R9
    ring_vc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ring_ready && ring_valid) |-> (out_vc >= ring_vc));

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk != 2'd0 && $past(out_valid && !out_ready) &&
         $stable({xbar_valid, xbar_kind, xbar_vc, xbar_flit,
                  ring_valid, ring_kind, ring_vc, ring_flit,
                  core_valid, core_kind, core_vc, core_flit}))
        |-> ($stable(out_flit) && $stable(out_kind) && out_valid));

endmodule

bind fbp_out_port fbp_out_port_chk #(.FLIT_W(FLIT_W), .VC_W(VC_W)) u_chk (.*);

// File: tb/fbp_out_port_test.sv
module fbp_out_port_test;

    localparam int FW = 64;
    localparam int VW = 1;
    localparam int MINV = 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fault_xbar = 0, fault_ni = 0;
    logic          xbar_valid = 0, ring_valid = 0, core_valid = 0;
    logic [1:0]    xbar_kind = 0, ring_kind = 0, core_kind = 0;
    logic [VW-1:0] xbar_vc = 0, ring_vc = 0, core_vc = 0;
    logic [FW-1:0] xbar_flit = 0, ring_flit = 0, core_flit = 0;
    logic          out_ready = 0;
    logic          xbar_ready, ring_ready, core_ready;
    logic          out_valid;
    logic [1:0]    out_kind;
    logic [VW-1:0] out_vc;
    logic [FW-1:0] out_flit;

    int n_vec = 0, n_bad = 0;
    bit done = 0;
    int m_lock = 0;   // 0 none, 1 xbar, 2 ring, 3 core
    bit m_rr = 0;     // 1: core preferred

    always #10 clk = ~clk;   // 50 MHz

    fbp_out_port #(.FLIT_W(FW), .VC_W(VW), .RING_MIN_VC(MINV)) uut (.*);

    function automatic bit starts(input logic [1:0] k);
        return k == 2'b01 || k == 2'b11;
    endfunction

    function automatic int exp_src();
        bit byp = fault_xbar | fault_ni;
        bit rg = ring_valid && starts(ring_kind);
        bit cg = core_valid && starts(core_kind);
        if (m_lock != 0) return m_lock;
        if (!byp) return (xbar_valid && starts(xbar_kind)) ? 1 : 0;
        if (rg && cg) return m_rr ? 3 : 2;
        if (rg) return 2;
        if (cg) return 3;
        return 0;
    endfunction

    task automatic step(input string tag);
        int s;
        logic ev; logic [1:0] ek; logic [VW-1:0] evc; logic [FW-1:0] ef;
        logic [2:0] erdy, ardy;
        #2;
        s = exp_src();
        ev = 0; ek = 0; evc = 0; ef = 0;
        case (s)
            1: begin ev = xbar_valid; ek = xbar_kind; evc = xbar_vc; ef = xbar_flit; end
            2: begin ev = ring_valid; ek = ring_kind;
                     evc = (ring_vc < VW'(MINV)) ? VW'(MINV) : ring_vc; ef = ring_flit; end
            3: begin ev = core_valid; ek = core_kind; evc = core_vc; ef = core_flit; end
            default: ;
        endcase
        erdy = {s == 3 && out_ready, s == 2 && out_ready, s == 1 && out_ready};
        ardy = {core_ready, ring_ready, xbar_ready};
        n_vec++;
        if (out_valid !== ev || ardy !== erdy ||
            (ev && (out_kind !== ek || out_vc !== evc || out_flit !== ef))) begin
            n_bad++;
            $display("FAIL %s: got v=%0b k=%0d vc=%0d d=%h rdy=%b, exp v=%0b k=%0d vc=%0d d=%h rdy=%b",
                     tag, out_valid, out_kind, out_vc, out_flit, ardy,
                     ev, ek, evc, ef, erdy);
        end
        @(posedge clk);
        if (ev && out_ready) begin
            if (m_lock == 0) begin
                if (s == 2) m_rr = 1;
                if (s == 3) m_rr = 0;
                if (ek == 2'b01) m_lock = s;
            end else if (ek == 2'b10 || ek == 2'b11) begin
                m_lock = 0;
            end
        end
        @(negedge clk);
    endtask

    task automatic drv_ring(input logic v, input logic [1:0] k, input logic [VW-1:0] vc);
        ring_valid = v; ring_kind = k; ring_vc = vc; ring_flit = {$urandom, $urandom};
    endtask
    task automatic drv_core(input logic v, input logic [1:0] k);
        core_valid = v; core_kind = k; core_vc = VW'($urandom); core_flit = {$urandom, $urandom};
    endtask
    task automatic drv_xbar(input logic v, input logic [1:0] k);
        xbar_valid = v; xbar_kind = k; xbar_vc = VW'($urandom); xbar_flit = {$urandom, $urandom};
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got running, exp finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: in reset, crossbar head still forwarded, nothing locked
        drv_xbar(1, 2'b01); drv_ring(1, 2'b01, 0); drv_core(1, 2'b01);
        out_ready = 0;
        step("R1 reset");
        m_lock = 0; m_rr = 0;
        rst_n = 1;
        out_ready = 1;
        drv_xbar(1, 2'b11);
        step("R1 after reset");
        // R2: crossbar packet in normal mode
        drv_xbar(1, 2'b01); step("R2 head");
        drv_xbar(1, 2'b00); drv_core(1, 2'b01); step("R2 body");
        drv_xbar(1, 2'b10); step("R2 tail");
        // R4: body/tail at idle not forwarded
        drv_xbar(1, 2'b00); step("R4 body idle");
        drv_xbar(1, 2'b10); step("R4 tail idle");
        // R3: bypass ignores crossbar
        fault_ni = 1;
        drv_xbar(1, 2'b11); drv_ring(0, 2'b01, 0); drv_core(0, 2'b01);
        step("R3 xbar ignored");
        // R6: contention alternates (reset preference: ring)
        for (int i = 0; i < 4; i++) begin
            drv_ring(1, 2'b11, 0); drv_core(1, 2'b11);
            step("R6 alternate");
        end
        // R5 + R9: ring packet locks, core kept out
        fault_ni = 0; fault_xbar = 1;
        drv_ring(1, 2'b01, 0); drv_core(1, 2'b01); step("R5 ring head R9");
        drv_ring(0, 2'b00, 1); step("R5 ring gap");
        // R7: stall
        drv_ring(1, 2'b00, 1); out_ready = 0; step("R7 stall");
        step("R7 stall held");
        out_ready = 1;
        // R8: flags drop mid-packet, still ring
        fault_xbar = 0; drv_xbar(1, 2'b01);
        step("R8 flags drop");
        drv_ring(1, 2'b10, 0); step("R8 tail");
        step("R8 xbar after tail");
        // random mix
        for (int i = 0; i < 4000; i++) begin
            if ($urandom % 8 == 0) begin
                fault_xbar = ($urandom % 3 == 0);
                fault_ni = ($urandom % 3 == 0);
            end
            drv_xbar(($urandom % 4) != 0, 2'($urandom));
            drv_ring(($urandom % 4) != 0, 2'($urandom), VW'($urandom));
            drv_core(($urandom % 4) != 0, 2'($urandom));
            out_ready = ($urandom % 4) != 0;
            step("R5 R6 R7 R8 random");
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule